// File: doc/BRIEF.md
# Self-Clocking Bit Cell Pulse Generator

This block turns a serial stream of data bits into the pulse train a disk read head would deliver. Time is cut into bit cells of two equal halves. The first half of every cell carries a clock pulse. The second half carries a pulse only when the bit for that cell is '1'. The output is active low: a pulse drives the line low for a fixed number of cycles, and the line rests high at all other times.

An upstream serializer feeds bits through a valid/value pair. The block raises a one-cycle strobe in the first cycle of each cell to ask for the next bit. It samples that bit only late in the cell, several cycles into the data half. This window lets memory fetch latency hide behind the clock half. If no bit is offered by the sampling point, the cell goes out as '0' and a sticky underrun flag is raised. Dropping the enable aborts the current cell at once and quiets the line.

With the default parameters at a 50 MHz clock, a half-cell is 35 cycles (0.7 us), a pulse is 20 cycles (0.4 us), and the bit is sampled at cell cycle 42.

Top module: `cellpulse_gen`

## Requirements
- R1: After a synchronous reset, pulse_n is 1, cell_start is 0 and underrun is 0. All three are registered outputs.
- R2: Number the cycles of a cell k = 0..2*HALF_CYCLES-1. While enable stays high, cells follow each other back to back with no gap. cell_start is 1 exactly in cycle k = 0 of each cell. The first cell begins in the cycle after the first clock edge at which enable is seen high.
- R3: In every cell, pulse_n is 0 for cycles k = 0 to PULSE_CYCLES-1 (the clock pulse). It then returns to 1.
- R4: Let D = HALF_CYCLES + SAMPLE_LAG. If the captured bit is 1, pulse_n is 0 for cycles k = D to D+PULSE_CYCLES-1. If the bit is 0, pulse_n stays 1 for the whole data half. Outside the two pulses pulse_n is 1: a value of 0 means pulse, 1 means no pulse.
- R5: The captured bit is bit_valid AND bit_value, sampled at the clock edge that ends cycle k = D-1. Values on bit_valid and bit_value in any other cycle have no effect on pulse_n.
- R6: If bit_valid is 0 at the sampling edge, the cell is sent as '0'. underrun becomes 1 from cycle k = D onward and stays 1 until reset.
- R7: If enable is 0 at a clock edge, then in the next cycle pulse_n is 1 and cell_start is 0, which aborts any cell in progress. When enable returns, a fresh cell starts at k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (50 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the cell sequencer while high |
| bit_valid | input | 1 | Upstream offers a bit for the current cell |
| bit_value | input | 1 | Value of the offered bit |
| pulse_n | output | 1 | Active-low pulse waveform |
| cell_start | output | 1 | One-cycle strobe in the first cycle of each cell; requests the next bit |
| underrun | output | 1 | Sticky flag: a cell found no valid bit at its sampling point |

## Verification
The bench offers bits with a latency that varies from cell to cell. This includes a bit that first becomes valid in the sampling cycle itself. A design that samples one cycle late or early would then drop the bit, or raise a false underrun. Before and after the sampling point, bit_value carries the opposite value. A design that reads the bit at the start of the data half, or keeps following the input after sampling, would then show the wrong data pulse. The bench also drops enable in the middle of a data pulse, including for a single cycle, and applies a reset while underrun is set. These catch pulses that keep running after an abort, restarts that resume the old cell position, and an underrun flag that is not sticky or is not cleared by reset.

// File: rtl/cellpulse_pkg.sv
package cellpulse_pkg;

  // Width of a position counter that spans a whole cell of two halves.
  function automatic int pos_width(input int half_cycles);
    return $clog2(2 * half_cycles);
  endfunction

  // True when pos lies within [first, first+len).
  function automatic logic in_window(input int pos, input int first, input int len);
    return (pos >= first) && (pos < first + len);
  endfunction

endpackage

// File: rtl/cellpulse_timer.sv
// Cell position sequencer: free-running position within a cell while enabled.
module cellpulse_timer #(
  parameter int HALF_CYCLES = 35,
  parameter int SAMPLE_LAG  = 8,
  parameter int POS_W       = cellpulse_pkg::pos_width(35)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  output logic             run_next,
  output logic [POS_W-1:0] pos_next,
  output logic             sample_now
);

  localparam int CELL_CYCLES = 2 * HALF_CYCLES;
  localparam int SAMPLE_POS  = HALF_CYCLES + SAMPLE_LAG - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_CYCLES - 1);
  localparam logic [POS_W-1:0] SAMP_POS = POS_W'(SAMPLE_POS);

  logic             running;
  logic [POS_W-1:0] pos;

  always_comb begin
    if (!enable) begin
      run_next = 1'b0;
      pos_next = '0;
    end else if (!running) begin
      run_next = 1'b1;
      pos_next = '0;
    end else begin
      run_next = 1'b1;
      pos_next = (pos == LAST_POS) ? '0 : pos + 1'b1;
    end
  end

  // The edge that ends the sampling cycle of a running cell captures the bit.
  assign sample_now = running && enable && (pos == SAMP_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pos     <= '0;
    end else begin
      running <= run_next;
      pos     <= pos_next;
    end
  end

endmodule

// File: rtl/cellpulse_sampler.sv
// Late bit capture and sticky underrun detection.
module cellpulse_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sample_now,
  input  logic bit_valid,
  input  logic bit_value,
  output logic bit_next,
  output logic underrun
);

  logic bit_q;
  logic captured;

  assign captured = bit_valid & bit_value;
  // Bit seen by the cycle that follows the current edge.
  assign bit_next = sample_now ? captured : bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= 1'b0;
      underrun <= 1'b0;
    end else if (sample_now) begin
      bit_q <= captured;
      if (!bit_valid) underrun <= 1'b1;
    end
  end

endmodule

// File: rtl/cellpulse_shaper.sv
// Registered pulse and strobe outputs derived from the next cell position.
module cellpulse_shaper #(
  parameter int HALF_CYCLES  = 35,
  parameter int SAMPLE_LAG   = 8,
  parameter int PULSE_CYCLES = 20,
  parameter int POS_W        = cellpulse_pkg::pos_width(35)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_next,
  input  logic [POS_W-1:0] pos_next,
  input  logic             bit_next,
  output logic             pulse_n,
  output logic             cell_start
);

  localparam int DATA_START = HALF_CYCLES + SAMPLE_LAG;

  logic clock_win;
  logic data_win;

  always_comb begin
    clock_win = cellpulse_pkg::in_window(int'(pos_next), 0, PULSE_CYCLES);
    data_win  = cellpulse_pkg::in_window(int'(pos_next), DATA_START, PULSE_CYCLES) && bit_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_n    <= 1'b1;
      cell_start <= 1'b0;
    end else begin
      pulse_n    <= !(run_next && (clock_win || data_win));
      cell_start <= run_next && (pos_next == '0);
    end
  end

endmodule

// File: rtl/cellpulse_gen.sv
// Self-clocking bit cell pulse generator (top).
module cellpulse_gen #(
  parameter int HALF_CYCLES  = 35,
  parameter int SAMPLE_LAG   = 8,
  parameter int PULSE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_valid,
  input  logic bit_value,
  output logic pulse_n,
  output logic cell_start,
  output logic underrun
);

  localparam int POS_W = cellpulse_pkg::pos_width(HALF_CYCLES);

  generate
    if (PULSE_CYCLES < 1 || SAMPLE_LAG < 1 || SAMPLE_LAG + PULSE_CYCLES > HALF_CYCLES
        || PULSE_CYCLES > HALF_CYCLES) begin : g_bad_cfg
      $error("cellpulse_gen: pulses must fit inside their half-cell");
    end
  endgenerate

  logic             run_next;
  logic [POS_W-1:0] pos_next;
  logic             sample_now;
  logic             bit_next;

  cellpulse_timer #(
    .HALF_CYCLES(HALF_CYCLES),
    .SAMPLE_LAG (SAMPLE_LAG),
    .POS_W      (POS_W)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .run_next  (run_next),
    .pos_next  (pos_next),
    .sample_now(sample_now)
  );

  cellpulse_sampler sampler_i (
    .clk       (clk),
    .rst       (rst),
    .sample_now(sample_now),
    .bit_valid (bit_valid),
    .bit_value (bit_value),
    .bit_next  (bit_next),
    .underrun  (underrun)
  );

  cellpulse_shaper #(
    .HALF_CYCLES (HALF_CYCLES),
    .SAMPLE_LAG  (SAMPLE_LAG),
    .PULSE_CYCLES(PULSE_CYCLES),
    .POS_W       (POS_W)
  ) shaper_i (
    .clk       (clk),
    .rst       (rst),
    .run_next  (run_next),
    .pos_next  (pos_next),
    .bit_next  (bit_next),
    .pulse_n   (pulse_n),
    .cell_start(cell_start)
  );

endmodule

// File: rtl/cellpulse_chk.sv
// Protocol checker bound to the pulse generator.
module cellpulse_chk #(
  parameter int HALF_CYCLES  = 35,
  parameter int PULSE_CYCLES = 20
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic pulse_n,
  input logic cell_start,
  input logic underrun
);

  localparam int CELL_CYCLES = 2 * HALF_CYCLES;

  logic [15:0] gap_cnt;
  logic        seen_start;
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt    <= '0;
      seen_start <= 1'b0;
      low_run    <= '0;
    end else begin
      if (cell_start) gap_cnt <= 16'd1;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
      seen_start <= enable ? (seen_start || cell_start) : 1'b0;
      if (pulse_n) low_run <= '0;
      else if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
    end
  end

  // R2
  cell_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cell_start && seen_start) |-> (gap_cnt == 16'(CELL_CYCLES)));

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cell_start |-> !pulse_n);

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pulse_n) && $past(enable) && !$past(rst)) |-> (low_run == 16'(PULSE_CYCLES)));

  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pulse_n && !cell_start));

endmodule

bind cellpulse_gen cellpulse_chk #(
  .HALF_CYCLES (HALF_CYCLES),
  .PULSE_CYCLES(PULSE_CYCLES)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .pulse_n   (pulse_n),
  .cell_start(cell_start),
  .underrun  (underrun)
);

// File: tb/cellpulse_gen_tb_top.sv
`timescale 1ns/1ps
module cellpulse_gen_tb_top;

  localparam int HALF  = 35;
  localparam int LAG   = 8;
  localparam int PULSE = 20;
  localparam int CELL  = 2 * HALF;
  localparam int DS    = HALF + LAG;
  localparam int SPOS  = DS - 1;
  localparam int LAST_CYC = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_value = 1'b0;
  logic pulse_n, cell_start, underrun;

  always #2.5 clk = ~clk;

  cellpulse_gen #(.HALF_CYCLES(HALF), .SAMPLE_LAG(LAG), .PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .bit_valid(bit_valid), .bit_value(bit_value),
    .pulse_n(pulse_n), .cell_start(cell_start), .underrun(underrun));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference model state
  bit m_run = 1'b0;
  bit m_bitq = 1'b0;
  bit m_under = 1'b0;
  bit last_rst = 1'b1;
  int m_k = 0;
  int m_cell = 0;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  function automatic bit seq_bit(input int n);
    return ((n * 13 + 5) % 7) > 3;
  endfunction

  // Cycle within the cell at which the upstream raises bit_valid.
  function automatic int latency(input int n);
    if (n == 20 || n == 38) return SPOS + 1;  // too late: underrun
    if (n % 4 == 1) return SPOS;              // valid exactly at sampling cycle
    return (n % 3) * 10 + 3;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic exp_start, exp_pn;
      string tag_pn, tag_cs, tag_ur;
      int lat;
      exp_start = m_run && (m_k == 0);
      exp_pn = !(m_run && (m_k < PULSE || (m_k >= DS && m_k < DS + PULSE && m_bitq)));
      if (last_rst) begin
        tag_pn = "R1"; tag_cs = "R1"; tag_ur = "R1";
      end else if (!m_run) begin
        tag_pn = "R7"; tag_cs = "R7"; tag_ur = "R6";
      end else begin
        tag_pn = (m_k < HALF) ? "R3" : "R4/R5";
        tag_cs = "R2";
        tag_ur = "R6";
      end
      chk(pulse_n, exp_pn, tag_pn, "pulse_n");
      chk(cell_start, exp_start, tag_cs, "cell_start");
      chk(underrun, m_under, tag_ur, "underrun");

      // Scenario schedule
      rst = (cyc < 4) || (cyc >= 2100 && cyc < 2103);
      enable = (cyc >= 6) && !(cyc >= 1000 && cyc < 1020) && (cyc != 1500);

      // Upstream serializer: opposite value outside the offer window (R5)
      if (m_run) begin
        lat = latency(m_cell);
        bit_valid = (m_k >= lat);
        bit_value = (m_k >= lat && m_k <= SPOS) ? seq_bit(m_cell) : !seq_bit(m_cell);
      end else begin
        bit_valid = 1'b0;
        bit_value = cyc[0];
      end

      // Model transition at the coming edge
      last_rst = rst;
      if (rst) begin
        m_run = 1'b0; m_k = 0; m_bitq = 1'b0; m_under = 1'b0;
      end else if (!enable) begin
        m_run = 1'b0; m_k = 0;
      end else if (!m_run) begin
        m_run = 1'b1; m_k = 0; m_cell++;
      end else begin
        if (m_k == SPOS) begin
          m_bitq = bit_valid & bit_value;
          if (!bit_valid) m_under = 1'b1;
        end
        m_k = (m_k == CELL - 1) ? 0 : m_k + 1;
        if (m_k == 0) m_cell++;
      end

      cyc++;
      if (cyc == LAST_CYC) begin
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R2 watchdog expired: actual cycle %0d expected %0d", cyc, LAST_CYC);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule